// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is a purely combinational execution slice for byte-wide bit-manipulation work inside an 8-bit processor datapath. Each call presents one opcode byte together with a page selector. The selector says which opcode table the byte belongs to. The block also receives the operand byte, the accumulator, a carry input and the current flag byte. The block returns the modified operand, a new accumulator value and a new flag byte. Two separate write-enables tell the surrounding sequencer which of the two values must be stored.

Three opcode tables are served:
- The bit page covers eight rotate and shift kinds, bit test, bit clear and bit set.
- The main page contributes only the four short accumulator rotates.
- The extended page contributes the two nibble rotates, which exchange 4-bit groups between the accumulator and a memory byte.

Prefix decoding, indexed address arithmetic and bus sequencing live elsewhere. The caller supplies the byte that was fetched or read.

Flag byte layout used throughout: bit 7 sign, bit 6 zero, bit 5 copy of result bit 5, bit 4 half carry, bit 3 copy of result bit 3, bit 2 parity (1 = even number of ones), bit 1 subtract, bit 0 carry.

Top module: `rsb_unit`

## Requirements
- R1: With `page_sel`=0 and `op_code[7:6]`=00, `op_code[5:3]` picks the shift kind:
  - 0 rotate left circular, 1 rotate right circular
  - 2 rotate left through `carry_in`, 3 rotate right through `carry_in`
  - 4 shift left with 0 in, 5 shift right keeping bit 7
  - 6 shift left with 1 in, 7 shift right with 0 in

  The shifted byte appears on `result` with `result_we`=1, and `acc_we`=0.
- R2: For that shift group, `flags_out` has bit 7 = result bit 7, bit 6 = (result==0), bits 5 and 3 copied from result, bit 4 = 0, bit 2 = even parity of result, bit 1 = 0, and bit 0 = the bit shifted out.
- R3: With `page_sel`=0 and `op_code[7:6]`=01 (bit test of bit `op_code[5:3]`), no write-enable is set and `result` equals `operand`. Bit 6 and bit 2 are both 1 exactly when the tested bit is 0. Bit 7 is 1 only when index 7 is tested and it is 1. Bits 5 and 3 are copied from `operand`, bit 4 is 1, bit 1 is 0, and bit 0 keeps `flags_in[0]`.
- R4: With `page_sel`=0 and `op_code[7:6]`=10 or 11, the indexed bit of `operand` is cleared (10) or set (11). The value appears on `result` with `result_we`=1 and `flags_out`=`flags_in`.
- R5: With `page_sel`=1, the codes 07h, 0Fh, 17h and 1Fh rotate `acc_in` in the same way as shift kinds 0 to 3. The rotated value is driven on `acc_out` with `acc_we`=1 and `result_we`=0. Bits 7, 6 and 2 of `flags_in` are kept, bits 5 and 3 come from the new accumulator, bits 4 and 1 are cleared, and bit 0 takes the bit shifted out.
- R6: With `page_sel`=2, code 6Fh gives `result`={operand[3:0],acc_in[3:0]} and `acc_out`={acc_in[7:4],operand[7:4]}. Code 67h gives `result`={acc_in[3:0],operand[7:4]} and `acc_out`={acc_in[7:4],operand[3:0]}. Both write-enables are 1.
- R7: For the two nibble rotates, `flags_out` bits 7, 6, 5, 3 and 2 follow the new accumulator (sign, zero, copies, even parity), bits 4 and 1 are 0, and bit 0 keeps `flags_in[0]`.
- R8: `page_sel`=3, or any code on page 1 or 2 other than those above, has no effect: both write-enables are 0, `result`=`operand`, `acc_out`=`acc_in` and `flags_out`=`flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| page_sel | input | 2 | Opcode table: 0 bit page, 1 main page, 2 extended page, 3 none |
| op_code | input | 8 | Opcode byte within the selected table |
| operand | input | 8 | Register or memory byte being worked on |
| acc_in | input | 8 | Current accumulator |
| carry_in | input | 1 | Carry fed into the through-carry rotates |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | New operand or memory byte |
| result_we | output | 1 | Store `result` back to the operand location |
| acc_out | output | 8 | New accumulator |
| acc_we | output | 1 | Store `acc_out` into the accumulator |
| flags_out | output | 8 | New flag byte |

## Verification
The block holds no state, so a wrong internal decode shows up at the ports in the same evaluation. Three kinds of fault are possible:
- A misdecoded group shows as a write-enable on the wrong output, or a flag byte that should have been passed through.
- A wrong shift kind changes `result` or carry bit 0 for almost every operand.
- A wrong nibble wiring shows on `acc_out` or `result` for any operand whose nibbles differ.

The stimulus is exhaustive over every opcode, operand and carry on the first two pages, and over every opcode and operand on the third. A fault that hits only one opcode or one operand value therefore cannot hide.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;
  localparam int unsigned IW = $clog2(DW);

  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_N = 1;
  localparam int unsigned FL_P = 2;
  localparam int unsigned FL_X = 3;
  localparam int unsigned FL_H = 4;
  localparam int unsigned FL_Y = 5;
  localparam int unsigned FL_Z = 6;
  localparam int unsigned FL_S = 7;

  typedef logic [DW-1:0] byte_t;

  typedef enum logic [2:0] {
    U_NONE, U_SHIFT, U_BTEST, U_BRES, U_BSET, U_AROT, U_NIB
  } unit_e;

  // Encoding equals opcode bits 5:3; bit 0 set means a rightward move.
  typedef enum logic [2:0] {
    SK_RLC, SK_RRC, SK_RL, SK_RR, SK_SLA, SK_SRA, SK_SLL, SK_SRL
  } skind_e;

  typedef struct packed {
    unit_e        unit;
    skind_e       kind;
    logic [IW-1:0] idx;
    logic         nib_left;
  } ctrl_t;

  function automatic logic even_par(byte_t v);
    return ~^v;
  endfunction

  // Sign, zero, copy bits and parity from a value; carry supplied.
  function automatic byte_t szp_flags(byte_t r, logic c);
    byte_t f;
    f        = '0;
    f[FL_S]  = r[DW-1];
    f[FL_Z]  = (r == '0);
    f[FL_Y]  = r[FL_Y];
    f[FL_X]  = r[FL_X];
    f[FL_P]  = even_par(r);
    f[FL_C]  = c;
    return f;
  endfunction

  // Returns {carry_out, shifted_value}.
  function automatic logic [DW:0] shift_op(skind_e k, byte_t v, logic cin);
    logic fill;
    logic [DW:0] o;
    if (k[0] == 1'b0) begin
      unique case (k)
        SK_RLC:  fill = v[DW-1];
        SK_RL:   fill = cin;
        SK_SLA:  fill = 1'b0;
        default: fill = 1'b1;
      endcase
      o = {v[DW-1], v[DW-2:0], fill};
    end else begin
      unique case (k)
        SK_RRC:  fill = v[0];
        SK_RR:   fill = cin;
        SK_SRA:  fill = v[DW-1];
        default: fill = 1'b0;
      endcase
      o = {v[0], fill, v[DW-1:1]};
    end
    return o;
  endfunction

  function automatic byte_t bit_mask(logic [IW-1:0] idx);
    return byte_t'(1) << idx;
  endfunction

endpackage

// File: rtl/rsb_decode.sv
module rsb_decode
  import rsb_pkg::*;
(
  input  logic [1:0]    page_sel,
  input  logic [DW-1:0] op_code,
  output ctrl_t         ctrl,
  output logic          dec_writes_operand,
  output logic          dec_writes_acc
);

  logic arot_code;
  logic nib_code;

  assign arot_code = (op_code[7:5] == 3'b000) && (op_code[2:0] == 3'b111);
  assign nib_code  = (op_code[7:4] == 4'h6)   && (op_code[2:0] == 3'b111);

  always_comb begin
    ctrl.unit     = U_NONE;
    ctrl.kind     = skind_e'(op_code[5:3]);
    ctrl.idx      = op_code[5:3];
    ctrl.nib_left = op_code[3];
    unique case (page_sel)
      2'd0: begin
        unique case (op_code[7:6])
          2'b00:   ctrl.unit = U_SHIFT;
          2'b01:   ctrl.unit = U_BTEST;
          2'b10:   ctrl.unit = U_BRES;
          default: ctrl.unit = U_BSET;
        endcase
      end
      2'd1:    if (arot_code) ctrl.unit = U_AROT;
      2'd2:    if (nib_code)  ctrl.unit = U_NIB;
      default: ctrl.unit = U_NONE;
    endcase
  end

  assign dec_writes_operand = (ctrl.unit == U_SHIFT) || (ctrl.unit == U_BRES) ||
                              (ctrl.unit == U_BSET)  || (ctrl.unit == U_NIB);
  assign dec_writes_acc     = (ctrl.unit == U_AROT)  || (ctrl.unit == U_NIB);

  always_comb begin
    if (!$isunknown({page_sel, op_code})) begin
      // R8: the empty page never yields a unit
      p_empty_page_r8: assert (page_sel != 2'd3 || ctrl.unit == U_NONE)
        else $error("page 3 decoded to a unit");
      // R5: accumulator rotates only come from the main page
      p_arot_page_r5: assert (ctrl.unit != U_AROT || page_sel == 2'd1)
        else $error("accumulator rotate outside page 1");
    end
  end

endmodule

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
(
  input  skind_e        kind,
  input  logic          acc_mode,
  input  logic [DW-1:0] val,
  input  logic          cin,
  input  logic [DW-1:0] flags_in,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic [DW-1:0] flags_out
);

  logic [DW:0] packed_out;
  byte_t       full_flags;

  assign packed_out = shift_op(kind, val, cin);
  assign res        = packed_out[DW-1:0];
  assign cout       = packed_out[DW];
  assign full_flags = szp_flags(res, cout);

  always_comb begin
    if (acc_mode) begin
      flags_out       = flags_in;
      flags_out[FL_Y] = res[FL_Y];
      flags_out[FL_X] = res[FL_X];
      flags_out[FL_H] = 1'b0;
      flags_out[FL_N] = 1'b0;
      flags_out[FL_C] = cout;
    end else begin
      flags_out = full_flags;
    end
  end

  always_comb begin
    if (!$isunknown({kind, acc_mode, val, cin, flags_in})) begin
      // R1: circular rotates conserve the number of ones
      p_circ_conserve_r1: assert (!(kind == SK_RLC || kind == SK_RRC) ||
                                  $countones(res) == $countones(val))
        else $error("circular rotate changed popcount");
      // R2: the carry out is always one of the two edge bits of the input
      p_carry_edge_r2: assert (cout == val[DW-1] || cout == val[0])
        else $error("carry out not an edge bit");
      // R5: accumulator mode never alters sign, zero or parity
      p_acc_keep_r5: assert (!acc_mode || (flags_out[FL_S] == flags_in[FL_S] &&
                             flags_out[FL_Z] == flags_in[FL_Z] &&
                             flags_out[FL_P] == flags_in[FL_P]))
        else $error("accumulator rotate touched S/Z/P");
    end
  end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop
  import rsb_pkg::*;
(
  input  unit_e         unit,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] flags_in,
  output logic [DW-1:0] res,
  output logic [DW-1:0] flags_out
);

  byte_t mask;
  logic  tested_zero;

  assign mask        = bit_mask(idx);
  assign tested_zero = ((val & mask) == '0);

  always_comb begin
    res       = val;
    flags_out = flags_in;
    unique case (unit)
      U_BRES: res = val & ~mask;
      U_BSET: res = val | mask;
      U_BTEST: begin
        flags_out       = '0;
        flags_out[FL_S] = (idx == IW'(DW - 1)) && !tested_zero;
        flags_out[FL_Z] = tested_zero;
        flags_out[FL_Y] = val[FL_Y];
        flags_out[FL_H] = 1'b1;
        flags_out[FL_X] = val[FL_X];
        flags_out[FL_P] = tested_zero;
        flags_out[FL_C] = flags_in[FL_C];
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({unit, idx, val, flags_in})) begin
      // R4: clear/set moves at most one bit
      p_one_bit_r4: assert ($countones(res ^ val) <= 1)
        else $error("bit op changed more than one bit");
      // R3: zero and parity agree on a bit test
      p_test_zp_r3: assert (unit != U_BTEST || flags_out[FL_Z] == flags_out[FL_P])
        else $error("bit test Z/P disagree");
    end
  end

endmodule

// File: rtl/rsb_nibble.sv
module rsb_nibble
  import rsb_pkg::*;
(
  input  logic          left,
  input  logic [DW-1:0] mem,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] flags_in,
  output logic [DW-1:0] mem_new,
  output logic [DW-1:0] acc_new,
  output logic [DW-1:0] flags_out
);

  logic [NW-1:0] a_lo, m_hi, m_lo;

  assign a_lo = acc[NW-1:0];
  assign m_hi = mem[DW-1:NW];
  assign m_lo = mem[NW-1:0];

  always_comb begin
    if (left) begin
      mem_new = {m_lo, a_lo};
      acc_new = {acc[DW-1:NW], m_hi};
    end else begin
      mem_new = {a_lo, m_hi};
      acc_new = {acc[DW-1:NW], m_lo};
    end
    flags_out = szp_flags(acc_new, flags_in[FL_C]);
  end

  always_comb begin
    if (!$isunknown({left, mem, acc, flags_in})) begin
      // R6: the upper accumulator nibble never moves
      p_acc_hi_r6: assert (acc_new[DW-1:NW] == acc[DW-1:NW])
        else $error("upper accumulator nibble moved");
      // R6: the three rotating nibbles are only permuted
      p_conserve_r6: assert ($countones({mem_new, acc_new}) == $countones({mem, acc}))
        else $error("nibble rotate lost bits");
    end
  end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic [1:0]    page_sel,
  input  logic [DW-1:0] op_code,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] acc_in,
  input  logic          carry_in,
  input  logic [DW-1:0] flags_in,
  output logic [DW-1:0] result,
  output logic          result_we,
  output logic [DW-1:0] acc_out,
  output logic          acc_we,
  output logic [DW-1:0] flags_out
);

  ctrl_t ctrl;
  logic  dec_writes_operand, dec_writes_acc;

  logic          sh_acc_mode, sh_cout;
  logic [DW-1:0] sh_in, sh_res, sh_flags;
  logic [DW-1:0] bo_res, bo_flags;
  logic [DW-1:0] nb_mem, nb_acc, nb_flags;

  rsb_decode u_dec (
    .page_sel           (page_sel),
    .op_code            (op_code),
    .ctrl               (ctrl),
    .dec_writes_operand (dec_writes_operand),
    .dec_writes_acc     (dec_writes_acc)
  );

  assign sh_acc_mode = (ctrl.unit == U_AROT);
  assign sh_in       = sh_acc_mode ? acc_in : operand;

  rsb_shift u_shift (
    .kind      (ctrl.kind),
    .acc_mode  (sh_acc_mode),
    .val       (sh_in),
    .cin       (carry_in),
    .flags_in  (flags_in),
    .res       (sh_res),
    .cout      (sh_cout),
    .flags_out (sh_flags)
  );

  rsb_bitop u_bit (
    .unit      (ctrl.unit),
    .idx       (ctrl.idx),
    .val       (operand),
    .flags_in  (flags_in),
    .res       (bo_res),
    .flags_out (bo_flags)
  );

  rsb_nibble u_nib (
    .left      (ctrl.nib_left),
    .mem       (operand),
    .acc       (acc_in),
    .flags_in  (flags_in),
    .mem_new   (nb_mem),
    .acc_new   (nb_acc),
    .flags_out (nb_flags)
  );

  always_comb begin
    result    = operand;
    acc_out   = acc_in;
    flags_out = flags_in;
    unique case (ctrl.unit)
      U_SHIFT: begin
        result    = sh_res;
        flags_out = sh_flags;
      end
      U_BTEST, U_BRES, U_BSET: begin
        result    = bo_res;
        flags_out = bo_flags;
      end
      U_AROT: begin
        acc_out   = sh_res;
        flags_out = sh_flags;
      end
      U_NIB: begin
        result    = nb_mem;
        acc_out   = nb_acc;
        flags_out = nb_flags;
      end
      default: ;
    endcase
  end

  assign result_we = dec_writes_operand;
  assign acc_we    = dec_writes_acc;

  always_comb begin
    if (!$isunknown({page_sel, op_code, operand, acc_in, carry_in, flags_in})) begin
      // R8: an idle request leaves every output at its input
      p_idle_r8: assert (ctrl.unit != U_NONE ||
                         (!result_we && !acc_we && flags_out == flags_in &&
                          result == operand && acc_out == acc_in))
        else $error("idle request had an effect");
      // R2: shift and accumulator rotates clear H and N
      p_hn_clear_r2: assert (!(ctrl.unit == U_SHIFT || ctrl.unit == U_AROT) ||
                             (flags_out[FL_H] == 1'b0 && flags_out[FL_N] == 1'b0))
        else $error("H or N left set after rotate");
      // R4: clear and set never change flags
      p_flags_hold_r4: assert (!(ctrl.unit == U_BRES || ctrl.unit == U_BSET) ||
                               flags_out == flags_in)
        else $error("bit clear/set changed flags");
      // R3: a bit test never requests a store
      p_test_nowrite_r3: assert (ctrl.unit != U_BTEST || (!result_we && !acc_we))
        else $error("bit test requested a write");
      // R7: nibble rotates keep the carry
      p_nib_carry_r7: assert (ctrl.unit != U_NIB || flags_out[FL_C] == flags_in[FL_C])
        else $error("nibble rotate changed carry");
    end
  end

endmodule

// File: tb/tb_rsb_unit.sv
module tb_rsb_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] page_sel = 2'd3;
  logic [7:0] op_code = '0, operand = '0, acc_in = '0, flags_in = '0;
  logic       carry_in = 1'b0;
  logic [7:0] result, acc_out, flags_out;
  logic       result_we, acc_we;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rsb_unit dut (
    .page_sel (page_sel), .op_code (op_code), .operand (operand),
    .acc_in (acc_in), .carry_in (carry_in), .flags_in (flags_in),
    .result (result), .result_we (result_we), .acc_out (acc_out),
    .acc_we (acc_we), .flags_out (flags_out)
  );

  typedef struct packed {
    logic [7:0] r; logic rw; logic [7:0] ao; logic aw; logic [7:0] fo;
  } exp_t;

  function automatic logic parity_even(logic [7:0] v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += v[i];
    return (ones % 2) == 0;
  endfunction

  // Returns {carry, value} for shift kind n.
  function automatic logic [8:0] ref_shift(int n, logic [7:0] v, logic c);
    logic [8:0] o;
    case (n)
      0: o = {v[7], v[6:0], v[7]};
      1: o = {v[0], v[0], v[7:1]};
      2: o = {v, c};
      3: o = {v[0], c, v[7:1]};
      4: o = {v, 1'b0};
      5: o = {v[0], v[7], v[7:1]};
      6: o = {v, 1'b1};
      default: o = {v[0], 1'b0, v[7:1]};
    endcase
    return o;
  endfunction

  function automatic exp_t ref_model(logic [1:0] pg, logic [7:0] op, logic [7:0] v,
                                     logic [7:0] a, logic c, logic [7:0] f);
    exp_t e;
    logic [8:0] s;
    int n = int'(op[5:3]);
    e.r = v; e.rw = 1'b0; e.ao = a; e.aw = 1'b0; e.fo = f;
    if (pg == 2'd0) begin
      case (op[7:6])
        2'b00: begin
          s = ref_shift(n, v, c);
          e.r = s[7:0]; e.rw = 1'b1;
          e.fo = {s[7], s[7:0] == 8'h00, s[5], 1'b0, s[3], parity_even(s[7:0]), 1'b0, s[8]};
        end
        2'b01: begin
          e.fo = {(n == 7) && v[7], !v[n], v[5], 1'b1, v[3], !v[n], 1'b0, f[0]};
        end
        2'b10: begin e.r = v; e.r[n] = 1'b0; e.rw = 1'b1; end
        default: begin e.r = v; e.r[n] = 1'b1; e.rw = 1'b1; end
      endcase
    end else if (pg == 2'd1) begin
      if (op == 8'h07 || op == 8'h0F || op == 8'h17 || op == 8'h1F) begin
        s = ref_shift(n, a, c);
        e.ao = s[7:0]; e.aw = 1'b1;
        e.fo = {f[7], f[6], s[5], 1'b0, s[3], f[2], 1'b0, s[8]};
      end
    end else if (pg == 2'd2) begin
      if (op == 8'h6F || op == 8'h67) begin
        if (op == 8'h6F) begin e.r = {v[3:0], a[3:0]}; e.ao = {a[7:4], v[7:4]}; end
        else             begin e.r = {a[3:0], v[7:4]}; e.ao = {a[7:4], v[3:0]}; end
        e.rw = 1'b1; e.aw = 1'b1;
        e.fo = {e.ao[7], e.ao == 8'h00, e.ao[5], 1'b0, e.ao[3], parity_even(e.ao), 1'b0, f[0]};
      end
    end
    return e;
  endfunction

  function automatic string tag_data(logic [1:0] pg, logic [7:0] op);
    if (pg == 2'd0) return (op[7:6] == 2'b00) ? "R1" : (op[7:6] == 2'b01) ? "R3" : "R4";
    if (pg == 2'd1) return (op == 8'h07 || op == 8'h0F || op == 8'h17 || op == 8'h1F) ? "R5" : "R8";
    if (pg == 2'd2) return (op == 8'h6F || op == 8'h67) ? "R6" : "R8";
    return "R8";
  endfunction

  function automatic string tag_flag(logic [1:0] pg, logic [7:0] op);
    if (pg == 2'd0) return (op[7:6] == 2'b00) ? "R2" : (op[7:6] == 2'b01) ? "R3" : "R4";
    if (pg == 2'd2 && (op == 8'h6F || op == 8'h67)) return "R7";
    return tag_data(pg, op);
  endfunction

  task automatic check_outputs(logic [1:0] pg, logic [7:0] op);
    exp_t e = ref_model(pg, op, operand, acc_in, carry_in, flags_in);
    n_chk += 3;
    if ({result_we, result} !== {e.rw, e.r}) begin
      n_fail++;
      $display("FAIL %s pg=%0d op=%h v=%h: result/we actual %h/%b expected %h/%b",
               tag_data(pg, op), pg, op, operand, result, result_we, e.r, e.rw);
    end
    if ({acc_we, acc_out} !== {e.aw, e.ao}) begin
      n_fail++;
      $display("FAIL %s pg=%0d op=%h a=%h: acc/we actual %h/%b expected %h/%b",
               tag_data(pg, op), pg, op, acc_in, acc_out, acc_we, e.ao, e.aw);
    end
    if (flags_out !== e.fo) begin
      n_fail++;
      $display("FAIL %s pg=%0d op=%h v=%h c=%b: flags actual %h expected %h",
               tag_flag(pg, op), pg, op, operand, carry_in, flags_out, e.fo);
    end
  endtask

  task automatic apply_vec(logic [1:0] pg, logic [7:0] op, logic [7:0] v,
                           logic [7:0] a, logic c, logic [7:0] f);
    page_sel = pg; op_code = op; operand = v; acc_in = a; carry_in = c; flags_in = f;
    #1;
    check_outputs(pg, op);
  endtask

  // R8: while reset is held, the idle page must have no effect
  task automatic t_reset_idle();
    @(negedge clk);
    apply_vec(2'd3, 8'hCB, 8'h5A, 8'hA5, 1'b1, 8'hFF);
    apply_vec(2'd3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
  endtask

  // R1 R2 R3 R4: every bit-page code, operand and carry
  task automatic t_bit_page();
    int k = 0;
    for (int op = 0; op < 256; op++)
      for (int v = 0; v < 256; v++)
        for (int c = 0; c < 2; c++) begin
          if (k % 4 == 0) @(negedge clk);
          k++;
          apply_vec(2'd0, 8'(op), 8'(v), 8'(v) ^ 8'hC3, c[0], {8'(v)} ^ {8'(op)} ^ 8'h5A);
        end
  endtask

  // R5 R8: every main-page code with every accumulator and carry
  task automatic t_acc_page();
    int k = 0;
    for (int op = 0; op < 256; op++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++) begin
          if (k % 4 == 0) @(negedge clk);
          k++;
          apply_vec(2'd1, 8'(op), 8'(a) ^ 8'h3C, 8'(a), c[0], 8'(a * 7) ^ {7'd0, c[0]});
        end
  endtask

  // R6 R7 R8: every extended-page code with every memory byte
  task automatic t_nibble_page();
    int k = 0;
    for (int op = 0; op < 256; op++)
      for (int v = 0; v < 256; v++) begin
        if (k % 4 == 0) @(negedge clk);
        k++;
        apply_vec(2'd2, 8'(op), 8'(v), 8'(v * 13 + op), v[0], 8'(v) ^ 8'hA6);
      end
  endtask

  // Hand-worked corner cases with literal expectations
  task automatic t_corners();
    @(negedge clk);
    apply_vec(2'd0, 8'h30, 8'h00, 8'h00, 1'b0, 8'h00);  // R1 shift-in-one
    n_chk++;
    if (result !== 8'h01) begin
      n_fail++; $display("FAIL R1 shift-in-one: actual %h expected 01", result);
    end
    apply_vec(2'd0, 8'h28, 8'h80, 8'h00, 1'b0, 8'h00);  // R1 arithmetic right
    n_chk++;
    if (result !== 8'hC0) begin
      n_fail++; $display("FAIL R1 arith right: actual %h expected c0", result);
    end
    apply_vec(2'd0, 8'h7F, 8'h80, 8'h00, 1'b0, 8'h01);  // R3 test bit 7 set
    n_chk++;
    if (flags_out !== 8'h91) begin
      n_fail++; $display("FAIL R3 bit7 test: actual %h expected 91", flags_out);
    end
    apply_vec(2'd2, 8'h6F, 8'h12, 8'h34, 1'b0, 8'h00);  // R6 left nibble rotate
    n_chk++;
    if ({result, acc_out} !== {8'h24, 8'h31}) begin
      n_fail++; $display("FAIL R6 nibble left: actual %h/%h expected 24/31", result, acc_out);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      n_fail++;
      $display("FAIL R8 watchdog: actual cycles %0d expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    t_reset_idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_corners();
    t_bit_page();
    t_acc_page();
    t_nibble_page();
    done = 1'b1;
    finish_run();
  end

endmodule